// File: doc/BRIEF.md
# Reset qualifier and boot vector selector

This block sits between the raw external reset pin and the processor core. The pin is brought into the clock domain through a short synchronizer chain. It only counts as a reset once it has stayed high for two full machine cycles without a break, where one machine cycle is twelve clocks. A shorter pulse, or any low sample in the middle of a run, is treated as noise and the count starts again. A power-up indication forces the core into reset directly and sets a power-off flag. That flag stays set until software clears it with a one-cycle strobe.

When the qualified reset is released, the block works out where the core starts fetching. The normal start address is 0000H. If the sampled program-store-enable level is low at that point, or the boot status bit is 1, the core starts at the boot address instead. The boot address has the 8-bit boot vector as its high byte and 00H as its low byte. The address comes out together with a one-cycle valid strobe.

The start address is a one-beat stream with no back-pressure. The program-counter load logic must accept it in the cycle the strobe is high, and the block neither holds nor repeats it. The block keeps no memory of its own. A pin reset therefore leaves on-chip data storage untouched, and only the core reset line is driven.

Top module: `boot_reset_seq`

## Requirements
- R1: While pwr_up_i is high, core_rst_o is 1 and pof_o is 1 from the next rising clock edge onward.
- R2: Once set, pof_o stays 1 until a clock edge that samples pof_clr_i=1 with pwr_up_i=0, which makes it 0. A pin reset never sets it.
- R3: A clock edge that samples pof_clr_i=1 and pwr_up_i=1 together leaves pof_o at 1.
- R4: A pin that is high for fewer than 24 consecutive sampled clock edges never asserts core_rst_o, and a single low sample restarts the count.
- R5: A pin that is high at 24 or more consecutive edges, starting at edge 1, makes core_rst_o rise at edge 26. The 2-flop synchronizer adds two edges to the 24 counted samples.
- R6: core_rst_o stays high while the pin stays high. When edge M is the first to sample the pin low, core_rst_o falls at edge M+2. After power-up it falls at the first edge that samples pwr_up_i low.
- R7: When core_rst_o falls at edge E, start_vld_o is 1 for exactly the cycle after edge E+1. If pse_lvl_i=1 and boot_stat_i=0 at edge E+1, start_addr_o is 0000H.
- R8: If pse_lvl_i=0 at edge E+1, start_addr_o is {boot_vec_i, 8'h00}, with the vector in bits 15:8 and zero in bits 7:0.
- R9: If boot_stat_i=1 at edge E+1, start_addr_o is {boot_vec_i, 8'h00} whatever the level of pse_lvl_i.
- R10: start_vld_o pulses exactly once for each fall of core_rst_o, never lasts two cycles, and never rises when no reset was qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_pin_i | input | 1 | Raw asynchronous reset pin, active high |
| pwr_up_i | input | 1 | Power-up indication; holds the block and core in reset |
| pse_lvl_i | input | 1 | Sampled program-store-enable level; 0 selects the boot address |
| boot_stat_i | input | 1 | Boot status bit; 1 selects the boot address |
| boot_vec_i | input | 8 | Boot vector, used as the high byte of the boot address |
| pof_clr_i | input | 1 | Software strobe that clears the power-off flag |
| core_rst_o | output | 1 | Qualified reset to the core, active high |
| start_addr_o | output | 16 | Program counter start address |
| start_vld_o | output | 1 | One-cycle valid for start_addr_o |
| pof_o | output | 1 | Power-off flag |

## Verification
The bench sweeps the pin pulse length from 1 to 30 clocks. This covers both sides of the 24-sample threshold: a counter that is one short or one long would accept a 23-clock pulse or reject a 24-clock one. It also measures the rise edge, fall edge and strobe edge exactly, which catches a missing or extra synchronizer stage. A pulse broken by one low sample targets a counter that pauses instead of restarting. Each exit cycles through the four combinations of pin level and status bit with a changing vector. The clear strobe is given in the same cycle as power-up, which targets a flag that gives clear the priority over set.

// File: rtl/boot_rst_pkg.sv
package boot_rst_pkg;
  // Reason the start address was chosen at reset exit.
  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_PIN   = 2'd1,
    SRC_STAT  = 2'd2
  } start_src_e;

  function automatic start_src_e pick_src(input logic pse_lvl, input logic stat);
    if (stat)          return SRC_STAT;
    else if (!pse_lvl) return SRC_PIN;
    else               return SRC_ZERO;
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (clr_i) chain_q[0] <= 1'b0;
          else       chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i) begin
          if (clr_i) chain_q[g] <= 1'b0;
          else       chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int QUAL_CLKS = 24
) (
  input  logic clk_i,
  input  logic force_i,
  input  logic lvl_i,
  output logic qual_o
);
  localparam int CNT_W = (QUAL_CLKS > 1) ? $clog2(QUAL_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CLKS - 1);

  logic [CNT_W-1:0] run_q;
  logic             qual_q;

  // run_q holds the number of consecutive high samples seen before this edge,
  // saturating at LAST; any low sample restarts it.
  always_ff @(posedge clk_i) begin
    if (force_i || !lvl_i)   run_q <= '0;
    else if (run_q != LAST)  run_q <= run_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (force_i) qual_q <= 1'b1;
    else         qual_q <= lvl_i && (qual_q || run_q == LAST);
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/pof_flag.sv
module pof_flag (
  input  logic clk_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // Set wins over clear.
  always_ff @(posedge clk_i) begin
    if (set_i)      flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/boot_vec_sel.sv
module boot_vec_sel
  import boot_rst_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              init_i,
  input  logic              rst_q_i,
  input  logic              pse_lvl_i,
  input  logic              stat_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vld_o
);
  localparam int LOW_W = ADDR_W - VEC_W;

  logic              rst_d_q;
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  start_src_e        src;

  always_comb begin
    src = pick_src(pse_lvl_i, stat_i);
    case (src)
      SRC_PIN, SRC_STAT: addr_nxt = {vec_i, {LOW_W{1'b0}}};
      default:           addr_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (init_i) begin
      rst_d_q <= 1'b1;
      vld_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      rst_d_q <= rst_q_i;
      vld_q   <= rst_d_q && !rst_q_i;
      if (rst_d_q && !rst_q_i) addr_q <= addr_nxt;
    end
  end

  assign addr_o = addr_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int CLKS_PER_MC = 12,
  parameter int MIN_MC      = 2,
  parameter int VEC_W       = 8,
  parameter int ADDR_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_pin_i,
  input  logic              pwr_up_i,
  input  logic              pse_lvl_i,
  input  logic              boot_stat_i,
  input  logic [VEC_W-1:0]  boot_vec_i,
  input  logic              pof_clr_i,
  output logic              core_rst_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              start_vld_o,
  output logic              pof_o
);
  localparam int QUAL_CLKS = CLKS_PER_MC * MIN_MC;

  logic pin_sync;
  logic rst_q;

  rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .clr_i (pwr_up_i),
    .d_i   (rst_pin_i),
    .q_o   (pin_sync)
  );

  rst_qualifier #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
    .clk_i   (clk_i),
    .force_i (pwr_up_i),
    .lvl_i   (pin_sync),
    .qual_o  (rst_q)
  );

  pof_flag u_pof (
    .clk_i  (clk_i),
    .set_i  (pwr_up_i),
    .clr_i  (pof_clr_i),
    .flag_o (pof_o)
  );

  boot_vec_sel #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_sel (
    .clk_i     (clk_i),
    .init_i    (pwr_up_i),
    .rst_q_i   (rst_q),
    .pse_lvl_i (pse_lvl_i),
    .stat_i    (boot_stat_i),
    .vec_i     (boot_vec_i),
    .addr_o    (start_addr_o),
    .vld_o     (start_vld_o)
  );

  assign core_rst_o = rst_q;
endmodule

// File: rtl/boot_reset_seq_chk.sv
module boot_reset_seq_chk #(
  parameter int CLKS_PER_MC = 12,
  parameter int MIN_MC      = 2,
  parameter int VEC_W       = 8,
  parameter int ADDR_W      = 16
) (
  input logic              clk_i,
  input logic              rst_pin_i,
  input logic              pwr_up_i,
  input logic              pse_lvl_i,
  input logic              boot_stat_i,
  input logic [VEC_W-1:0]  boot_vec_i,
  input logic              pof_clr_i,
  input logic              core_rst_o,
  input logic [ADDR_W-1:0] start_addr_o,
  input logic              start_vld_o,
  input logic              pof_o
);
  localparam int QUAL = CLKS_PER_MC * MIN_MC;
  localparam int RW   = $clog2(QUAL + 1);

  // Independent window check on the raw pin: a run of QUAL high samples arms.
  logic [RW-1:0] run_q;
  logic          armed_q;

  always_ff @(posedge clk_i) begin
    if (pwr_up_i) begin
      run_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (!rst_pin_i)                 run_q <= '0;
      else if (run_q != RW'(QUAL))    run_q <= run_q + 1'b1;
      if (rst_pin_i && run_q == RW'(QUAL - 1)) armed_q <= 1'b1;
      else if (core_rst_o)                     armed_q <= 1'b0;
    end
  end

  p_pwr_release_r1: assert property (@(posedge clk_i)
    $fell(pwr_up_i) |-> core_rst_o && pof_o);

  p_pof_hold_r2: assert property (@(posedge clk_i) disable iff (pwr_up_i)
    pof_o && !pof_clr_i |=> pof_o);

  p_pof_clear_r2: assert property (@(posedge clk_i) disable iff (pwr_up_i)
    pof_clr_i |=> !pof_o);

  p_pof_no_set_r2: assert property (@(posedge clk_i) disable iff (pwr_up_i)
    !pof_o |=> !pof_o);

  p_qual_window_r4: assert property (@(posedge clk_i) disable iff (pwr_up_i)
    $rose(core_rst_o) |-> armed_q);

  p_vld_after_fall_r7: assert property (@(posedge clk_i) disable iff (pwr_up_i)
    start_vld_o |-> !core_rst_o && !$past(core_rst_o) && $past(core_rst_o, 2));

  p_zero_addr_r7: assert property (@(posedge clk_i) disable iff (pwr_up_i)
    start_vld_o && $past(pse_lvl_i) && !$past(boot_stat_i) |-> start_addr_o == '0);

  p_boot_addr_r8: assert property (@(posedge clk_i) disable iff (pwr_up_i)
    start_vld_o && ($past(boot_stat_i) || !$past(pse_lvl_i)) |->
      start_addr_o == {$past(boot_vec_i), {(ADDR_W-VEC_W){1'b0}}});

  p_vld_single_r10: assert property (@(posedge clk_i) disable iff (pwr_up_i)
    start_vld_o |=> !start_vld_o);
endmodule

bind boot_reset_seq boot_reset_seq_chk #(
  .CLKS_PER_MC (CLKS_PER_MC),
  .MIN_MC      (MIN_MC),
  .VEC_W       (VEC_W),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_pin_i    (rst_pin_i),
  .pwr_up_i     (pwr_up_i),
  .pse_lvl_i    (pse_lvl_i),
  .boot_stat_i  (boot_stat_i),
  .boot_vec_i   (boot_vec_i),
  .pof_clr_i    (pof_clr_i),
  .core_rst_o   (core_rst_o),
  .start_addr_o (start_addr_o),
  .start_vld_o  (start_vld_o),
  .pof_o        (pof_o)
);

// File: tb/test_boot_reset_seq.sv
module test_boot_reset_seq;
  logic        clk = 1'b0;
  logic        rst_pin, pwr_up, pse_lvl, boot_stat, pof_clr;
  logic [7:0]  boot_vec;
  logic        core_rst, start_vld, pof;
  logic [15:0] start_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  boot_reset_seq i_boot_reset_seq (
    .clk_i        (clk),
    .rst_pin_i    (rst_pin),
    .pwr_up_i     (pwr_up),
    .pse_lvl_i    (pse_lvl),
    .boot_stat_i  (boot_stat),
    .boot_vec_i   (boot_vec),
    .pof_clr_i    (pof_clr),
    .core_rst_o   (core_rst),
    .start_addr_o (start_addr),
    .start_vld_o  (start_vld),
    .pof_o        (pof)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_addr(input bit pse, input bit stat, input int vec);
    return (!pse || stat) ? (vec * 256) : 0;
  endfunction

  // Release power-up and check the exit sequence that follows.
  task automatic pwr_exit(input bit pse, input bit stat, input int vec, input string req);
    pse_lvl = pse; boot_stat = stat; boot_vec = vec[7:0]; pwr_up = 1'b0;
    @(negedge clk);
    chk(core_rst == 1'b0, "R6", "core_rst after power release", int'(core_rst), 0);
    chk(start_vld == 1'b0, "R7", "no strobe at fall edge", int'(start_vld), 0);
    @(negedge clk);
    chk(start_vld == 1'b1, "R7", "strobe one cycle after fall", int'(start_vld), 1);
    chk(int'(start_addr) == exp_addr(pse, stat, vec), req, "start address",
        int'(start_addr), exp_addr(pse, stat, vec));
    @(negedge clk);
    chk(start_vld == 1'b0, "R10", "strobe lasts one cycle", int'(start_vld), 0);
  endtask

  // Pin pulse of n sampled edges; measures rise, fall and strobe positions.
  task automatic pin_pulse(input int n, input bit pse, input bit stat, input int vec);
    int first_hi = -1, last_hi = -1, vld_cnt = 0, vld_at = -1, addr_seen = -1;
    pse_lvl = pse; boot_stat = stat; boot_vec = vec[7:0];
    rst_pin = 1'b1;
    for (int k = 1; k <= n + 40; k++) begin
      @(negedge clk);
      if (core_rst) begin
        if (first_hi < 0) first_hi = k;
        last_hi = k;
      end
      if (start_vld) begin
        vld_cnt++;
        vld_at = k;
        addr_seen = int'(start_addr);
      end
      if (k == n) rst_pin = 1'b0;
    end
    if (n < 24) begin
      chk(first_hi < 0, "R4", $sformatf("short pulse %0d rejected", n), first_hi, -1);
      chk(vld_cnt == 0, "R10", $sformatf("no strobe for pulse %0d", n), vld_cnt, 0);
    end else begin
      chk(first_hi == 26, "R5", $sformatf("rise edge for pulse %0d", n), first_hi, 26);
      chk(last_hi == n + 2, "R6", $sformatf("last high edge for pulse %0d", n), last_hi, n + 2);
      chk(vld_cnt == 1, "R10", $sformatf("strobe count for pulse %0d", n), vld_cnt, 1);
      chk(vld_at == n + 4, "R7", $sformatf("strobe edge for pulse %0d", n), vld_at, n + 4);
      chk(addr_seen == exp_addr(pse, stat, vec), (stat ? "R9" : (!pse ? "R8" : "R7")),
          $sformatf("address for pulse %0d", n), addr_seen, exp_addr(pse, stat, vec));
    end
    chk(pof == 1'b0, "R2", "pin reset leaves flag clear", int'(pof), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pwr_up = 1'b1; rst_pin = 1'b0; pse_lvl = 1'b1; boot_stat = 1'b0;
    boot_vec = 8'h00; pof_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(core_rst == 1'b1, "R1", "core reset during power-up", int'(core_rst), 1);
    chk(pof == 1'b1, "R1", "flag set during power-up", int'(pof), 1);
    chk(start_vld == 1'b0, "R10", "no strobe during power-up", int'(start_vld), 0);

    pwr_exit(1'b1, 1'b0, 8'h5A, "R7");
    repeat (5) @(negedge clk);
    chk(pof == 1'b1, "R2", "flag held without clear", int'(pof), 1);
    pof_clr = 1'b1;
    @(negedge clk);
    pof_clr = 1'b0;
    chk(pof == 1'b0, "R2", "flag cleared by strobe", int'(pof), 0);

    // Threshold sweep over pulse length and exit selections.
    for (int n = 1; n <= 30; n++) begin
      pin_pulse(n, !n[0], n[1], (n * 37 + 5) % 256);
    end

    // One low sample inside two 20-clock runs must restart the count.
    rst_pin = 1'b1;
    begin
      int seen = 0;
      for (int k = 1; k <= 80; k++) begin
        @(negedge clk);
        if (core_rst || start_vld) seen++;
        if (k == 20) rst_pin = 1'b0;
        if (k == 21) rst_pin = 1'b1;
        if (k == 41) rst_pin = 1'b0;
      end
      chk(seen == 0, "R4", "broken run rejected", seen, 0);
    end

    // Clear and power-up on the same edge: set wins.
    pwr_up = 1'b1; pof_clr = 1'b1;
    @(negedge clk);
    pof_clr = 1'b0;
    chk(pof == 1'b1, "R3", "set wins over clear", int'(pof), 1);
    chk(core_rst == 1'b1, "R1", "core reset on power-up", int'(core_rst), 1);
    @(negedge clk);
    pwr_exit(1'b1, 1'b1, 8'hA5, "R9");

    pwr_up = 1'b1;
    repeat (2) @(negedge clk);
    pwr_exit(1'b0, 1'b0, 8'h3C, "R8");
    pwr_up = 1'b1;
    repeat (2) @(negedge clk);
    pwr_exit(1'b0, 1'b1, 8'hFF, "R9");
    chk(pof == 1'b1, "R2", "flag held after exits", int'(pof), 1);
    pof_clr = 1'b1;
    @(negedge clk);
    pof_clr = 1'b0;
    chk(pof == 1'b0, "R2", "flag cleared again", int'(pof), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule